// File: doc/BRIEF.md
# Interrupt Input Priority Cell

This block is the per-line front end of an eight-input interrupt controller. It takes one raw interrupt request line, brings it into the system clock domain, and conditions it into a latched request. The priority resolver and the control logic read that request together with this line's in-service bit and mask bit. Eight copies sit side by side, and the resolver across them is built elsewhere.

A mode input picks how requests are taken. In edge mode an arming latch gates the request path. The latch is set while the synchronised line is low. Setting the in-service bit clears it, so a line that stays high after being serviced cannot raise a second request until it has gone low again. In level mode the arming latch is ignored and the line level alone drives the request. The controller raises a freeze strobe during acknowledge and poll sequences, and while it is high the request latch holds its value. A master clear, pulsed during the first initialisation write, returns the cell to its idle state.

All pins are plain control and status signals. No data stream passes through the cell, so there is no valid/ready handshake and no back-pressure.

Top module: `irq_prio_cell`

## Requirements
- R1: After reset, or on the clock edge where `mclr_i` is high, `req_latched_o`, `req_pr_o`, `in_service_o` and `mask_o` are 0 and the arming latch is set.
- R2: A change on `irq_raw_i` passes through two synchroniser stages and the request latch. When the cell is not frozen, the change shows on `req_latched_o` after the third rising clock edge and not earlier.
- R3: In edge mode (`edge_mode_i` = 1), a line that goes high while the cell is armed sets `req_latched_o` to 1.
- R4: In edge mode, a `set_isr_i` pulse disarms the cell. `req_latched_o` drops to 0 and stays 0 while the line stays high. A new request is accepted only after the line has been low long enough to re-arm.
- R5: In level mode (`edge_mode_i` = 0), `req_latched_o` follows the synchronised line, and `set_isr_i` does not clear it.
- R6: While `freeze_i` is 1, `req_latched_o` keeps its value whatever the line does. When `freeze_i` returns to 0, the latch follows its input again.
- R7: A `set_isr_i` pulse sets `in_service_o` to 1, and it stays 1 until a master clear.
- R8: A `mask_we_i` pulse loads `mask_d_i` into `mask_o`. While `mask_o` is 1, `req_pr_o` is 0 even though `req_latched_o` may be 1.
- R9: `mclr_i` takes priority over a `mask_we_i` or `set_isr_i` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | 1 | Raw interrupt request line, asynchronous |
| edge_mode_i | input | 1 | 1 = edge-triggered, 0 = level-triggered |
| mclr_i | input | 1 | Master clear strobe |
| freeze_i | input | 1 | Holds the request latch during acknowledge and poll |
| set_isr_i | input | 1 | Pulse that marks this level as in service |
| mask_we_i | input | 1 | Mask bit write strobe |
| mask_d_i | input | 1 | Value written to the mask bit |
| req_latched_o | output | 1 | Request latch output |
| req_pr_o | output | 1 | Request as seen by the priority resolver, after masking |
| in_service_o | output | 1 | In-service bit |
| mask_o | output | 1 | Mask bit |

## Verification
The line is driven with low-high-low sequences in edge mode, with and without an in-service pulse in between. This separates arming from plain level tracking, because a held-high line must stay dead after service in edge mode but not in level mode. The same high and low levels are repeated with freeze held, which shows that the latch holds rather than follows. Mask writes are made while a request is latched, which separates the latched output from the resolver-facing one. A directed latency probe counts clock edges after a line change, and a clear that coincides with a mask write confirms which of the two wins.

// File: rtl/irq_cell_pkg.sv
package irq_cell_pkg;
  typedef enum logic {TRIG_LEVEL = 1'b0, TRIG_EDGE = 1'b1} trig_mode_e;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_arm_latch.sv
module irq_arm_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic mclr_i,
  input  logic set_isr_i,
  input  logic line_i,
  output logic armed_o
);
  // Priority: master clear arms, in-service disarms, a low line re-arms.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_o <= 1'b1;
    else if (mclr_i)    armed_o <= 1'b1;
    else if (set_isr_i) armed_o <= 1'b0;
    else if (!line_i)   armed_o <= 1'b1;
  end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch
  import irq_cell_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mclr_i,
  input  logic       freeze_i,
  input  trig_mode_e mode_i,
  input  logic       line_i,
  input  logic       armed_i,
  output logic       req_o
);
  logic gate_d;

  always_comb begin
    unique case (mode_i)
      TRIG_EDGE:  gate_d = line_i & armed_i;
      TRIG_LEVEL: gate_d = line_i;
      default:    gate_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         req_o <= 1'b0;
    else if (mclr_i)    req_o <= 1'b0;
    else if (!freeze_i) req_o <= gate_d;
  end
endmodule

// File: rtl/irq_prio_cell.sv
module irq_prio_cell
  import irq_cell_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw_i,
  input  logic edge_mode_i,
  input  logic mclr_i,
  input  logic freeze_i,
  input  logic set_isr_i,
  input  logic mask_we_i,
  input  logic mask_d_i,
  output logic req_latched_o,
  output logic req_pr_o,
  output logic in_service_o,
  output logic mask_o
);
  logic       line_s;
  logic       armed;
  trig_mode_e mode;

  assign mode = edge_mode_i ? TRIG_EDGE : TRIG_LEVEL;

  irq_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(irq_raw_i), .q_o(line_s)
  );

  irq_arm_latch u_arm (
    .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i), .set_isr_i(set_isr_i),
    .line_i(line_s), .armed_o(armed)
  );

  irq_req_latch u_req (
    .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i), .freeze_i(freeze_i),
    .mode_i(mode), .line_i(line_s), .armed_i(armed), .req_o(req_latched_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_service_o <= 1'b0;
    else if (mclr_i)    in_service_o <= 1'b0;
    else if (set_isr_i) in_service_o <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= 1'b0;
    else if (mclr_i)    mask_o <= 1'b0;
    else if (mask_we_i) mask_o <= mask_d_i;
  end

  assign req_pr_o = req_latched_o & ~mask_o;
endmodule

// File: rtl/irq_prio_cell_chk.sv
module irq_prio_cell_chk (
  input logic clk,
  input logic rst_n,
  input logic mclr_i,
  input logic freeze_i,
  input logic set_isr_i,
  input logic mask_we_i,
  input logic mask_d_i,
  input logic req_latched_o,
  input logic in_service_o,
  input logic mask_o
);
  a_r1_mclr_idle: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_i |=> (!req_latched_o && !in_service_o && !mask_o));

  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !mclr_i) |=> $stable(req_latched_o));

  a_r7_isr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (set_isr_i && !mclr_i) |=> in_service_o);

  a_r7_isr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && !mclr_i) |=> in_service_o);

  a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we_i && !mclr_i) |=> (mask_o == $past(mask_d_i)));

  a_r9_mclr_beats_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (mclr_i && mask_we_i) |=> !mask_o);
endmodule

bind irq_prio_cell irq_prio_cell_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mclr_i(mclr_i), .freeze_i(freeze_i),
  .set_isr_i(set_isr_i), .mask_we_i(mask_we_i), .mask_d_i(mask_d_i),
  .req_latched_o(req_latched_o), .in_service_o(in_service_o), .mask_o(mask_o)
);

// File: tb/tb_irq_prio_cell.sv
module tb_irq_prio_cell;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_raw_i = 1'b0, edge_mode_i = 1'b1, mclr_i = 1'b0, freeze_i = 1'b0;
  logic set_isr_i = 1'b0, mask_we_i = 1'b0, mask_d_i = 1'b0;
  logic req_latched_o, req_pr_o, in_service_o, mask_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  irq_prio_cell dut (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(irq_raw_i), .edge_mode_i(edge_mode_i),
    .mclr_i(mclr_i), .freeze_i(freeze_i), .set_isr_i(set_isr_i),
    .mask_we_i(mask_we_i), .mask_d_i(mask_d_i), .req_latched_o(req_latched_o),
    .req_pr_o(req_pr_o), .in_service_o(in_service_o), .mask_o(mask_o)
  );

  // {irq, edge, freeze, set_isr, mask_we, mask_d, mclr, e_req, e_pr, e_isr, e_mask}
  localparam int NV = 19;
  localparam logic [10:0] VEC [0:NV-1] = '{
    11'b0_1_0_0_0_0_0_0_0_0_0, // 0  R3 idle low
    11'b1_1_0_0_0_0_0_1_1_0_0, // 1  R3 rising while armed
    11'b1_1_0_1_0_0_0_0_0_1_0, // 2  R4 R7 service disarms
    11'b1_1_0_0_0_0_0_0_0_1_0, // 3  R4 held high stays dead
    11'b0_1_0_0_0_0_0_0_0_1_0, // 4  R4 low re-arms
    11'b1_1_0_0_0_0_0_1_1_1_0, // 5  R4 new request accepted
    11'b1_0_0_1_0_0_0_1_1_1_0, // 6  R5 level ignores service
    11'b0_0_0_0_0_0_0_0_0_1_0, // 7  R5 level follows low
    11'b1_0_1_0_0_0_0_0_0_1_0, // 8  R6 frozen low
    11'b1_0_0_0_0_0_0_1_1_1_0, // 9  R6 released
    11'b0_0_1_0_0_0_0_1_1_1_0, // 10 R6 frozen high
    11'b0_0_0_0_0_0_0_0_0_1_0, // 11 R6 released
    11'b1_0_0_0_1_1_0_1_0_1_1, // 12 R8 masked
    11'b1_0_0_0_1_0_0_1_1_1_0, // 13 R8 unmasked
    11'b1_0_0_0_0_0_1_1_1_0_0, // 14 R1 clear then level follows
    11'b1_1_0_0_1_1_1_1_1_0_0, // 15 R9 clear beats mask write
    11'b0_1_0_0_0_0_0_0_0_0_0, // 16 R3 low
    11'b1_1_1_0_0_0_0_0_0_0_0, // 17 R6 frozen in edge mode
    11'b1_1_0_0_0_0_0_1_1_0_0  // 18 R3 armed request after thaw
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  initial begin
    #300000;
    n_bad++; n_chk++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 req", req_latched_o, 1'b0);
    chk("R1 isr", in_service_o, 1'b0);
    chk("R1 mask", mask_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [10:0] v;
      v = VEC[i];
      irq_raw_i = v[10]; edge_mode_i = v[9]; freeze_i = v[8];
      set_isr_i = v[7]; mask_we_i = v[6]; mask_d_i = v[5]; mclr_i = v[4];
      @(negedge clk);
      set_isr_i = 1'b0; mask_we_i = 1'b0; mclr_i = 1'b0;
      repeat (3) @(negedge clk);
      chk($sformatf("vec%0d req", i), req_latched_o, v[3]);
      chk($sformatf("vec%0d pr", i), req_pr_o, v[2]);
      chk($sformatf("vec%0d isr", i), in_service_o, v[1]);
      chk($sformatf("vec%0d mask", i), mask_o, v[0]);
      freeze_i = 1'b0;
    end

    // R2 latency: level mode, line low settled, then raise
    edge_mode_i = 1'b0; irq_raw_i = 1'b0;
    repeat (4) @(negedge clk);
    irq_raw_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 not before third edge", req_latched_o, 1'b0);
    @(negedge clk);
    chk("R2 on third edge", req_latched_o, 1'b1);

    // R1 master clear empties in-service and re-arms
    set_isr_i = 1'b1; @(negedge clk); set_isr_i = 1'b0;
    chk("R7 isr set", in_service_o, 1'b1);
    mclr_i = 1'b1; @(negedge clk); mclr_i = 1'b0;
    chk("R1 mclr isr", in_service_o, 1'b0);
    chk("R1 mclr req", req_latched_o, 1'b0);

    // R9 clear beats a same-cycle service pulse
    set_isr_i = 1'b1; mclr_i = 1'b1; @(negedge clk);
    set_isr_i = 1'b0; mclr_i = 1'b0;
    chk("R9 mclr over set_isr", in_service_o, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule